// File: doc/BRIEF.md
# Cascadable DMA Request Arbiter

This block sits at the front of a first-level DMA controller and decides which of its request lines gets the system bus. It qualifies each incoming request with a per-channel mask and raises a hold request toward the processor. Once the processor acknowledges with its hold-acknowledge input, the block grants the highest-priority pending channel by driving that channel's acknowledge line.

Any channel can be flagged as a cascade channel, which means a second-level controller sits behind it. The downstream controller's request travels through the same fixed priority chain as any local requester. When a cascade channel wins, the block drives only the hold request and the acknowledge line. The enables for the address, control and end-of-process outputs stay low. An external end-of-process pulse has no effect while a cascade channel holds the bus, so the downstream controller keeps the bus until it drops its request.

Acknowledge polarity is programmable. It leaves reset as active-low with all lines high, and it can be switched to active-high so that an acknowledge line can feed a downstream hold-acknowledge input directly.

Top module: `dma_casc_arbiter`

## Requirements
- R1: From idle, `hrq` goes high on the clock edge after any channel has `dreq` high with its `mask` bit low. While it waits for `hlda`, `hrq` returns low on the edge after no such channel remains.
- R2: On the first edge with `hlda` high while `hrq` is high, the unmasked requesting channel with the lowest index wins (channel 0 highest, channel 3 lowest). At most one `dack` line is active at any time.
- R3: A channel whose `mask` bit is 1 neither raises `hrq` nor keeps a grant. This also applies to cascade channels.
- R4: A grant lasts while the winning channel's `dreq` stays high and unmasked. On the edge after that stops, `hrq` goes low and all `dack` lines return to inactive.
- R5: While a channel with its `casc_en` bit set (bit n = channel n) is granted, `addr_oe`, `ctrl_oe` and `eop_oe` stay 0, and `hrq` and that channel's `dack` stay active.
- R6: During a cascade grant, `eop_in` is ignored: `eop_take` stays 0 and the grant continues. During a normal grant, `eop_in` high drives `eop_take` high in the same cycle and ends the grant on the next edge.
- R7: While `rst_n` is low, and on the first edge after reset, `hrq`, `addr_oe`, `ctrl_oe`, `eop_oe` and `eop_take` are 0. All `dack` lines are 1 (active-low, inactive) whatever the value of `dack_hi`.
- R8: `dack_hi` is sampled on every clock edge. When the sampled value is 1, an active `dack` line is 1 and inactive lines are 0. When it is 0, an active line is 0 and inactive lines are 1.
- R9: While a channel with `casc_en` bit clear is granted, `addr_oe`, `ctrl_oe` and `eop_oe` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq | input | 4 | Per-channel service requests, active high |
| mask | input | 4 | Per-channel mask, 1 blocks the channel |
| casc_en | input | 4 | Per-channel cascade flag |
| dack_hi | input | 1 | Acknowledge polarity, 1 = active high |
| hlda | input | 1 | Hold acknowledge from the processor |
| eop_in | input | 1 | External end-of-process, active high |
| hrq | output | 1 | Hold request to the processor |
| dack | output | 4 | Per-channel acknowledge at programmed polarity |
| addr_oe | output | 1 | Enable for the address outputs |
| ctrl_oe | output | 1 | Enable for the read/write control outputs |
| eop_oe | output | 1 | Enable for the end-of-process output driver |
| eop_take | output | 1 | External end-of-process accepted for the current grant |

## Verification
A wrong grant register shows up on the `dack` lines on the edge after `hlda` is seen. It appears as the wrong channel, two active lines, or a grant that outlives its request. A stale cascade flag appears in the same cycle as output enables that are raised during a downstream grant, or as an `eop_take` pulse that ends that grant early. A polarity register that is wrong at reset inverts every `dack` line on the first edge after reset. The stimulus therefore checks each of these outputs one edge after every input change.

// File: rtl/dma_arb_pkg.sv
// Shared types for the cascadable DMA request arbiter.
// Assumes: a single clock domain; all users import this package.
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // no bus request outstanding
        ARB_WAIT = 2'd1,   // hold requested, waiting for acknowledge
        ARB_OWN  = 2'd2    // a channel owns the bus
    } arb_state_t;
endpackage

// File: rtl/dma_req_qual.sv
// Request qualifier: a channel counts as pending only when its request
// is high and its mask bit is low.
// Assumes: inputs are already synchronous to clk.
module dma_req_qual #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] qual,
    output logic           any_q
);
    // One gate per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign qual[g] = dreq[g] & ~mask[g];
    end
    assign any_q = |qual;
endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority picker: returns a one-hot vector of the lowest-index
// active input (index 0 has the highest priority).
// Assumes: purely combinational; an all-zero input gives all zeros.
module dma_prio_pick #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] pick
);
    // Scan upward and keep the first set bit.
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_grant_fsm.sv
// Grant sequencer: raises the hold request, latches the winning channel
// on hold acknowledge, and releases the grant when the winner's qualified
// request drops or, for a non-cascade grant, on external end-of-process.
// Assumes: pick is one-hot or zero; synchronous active-low reset.
module dma_grant_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] qual,
    input  logic           any_q,
    input  logic [NCH-1:0] pick,
    input  logic [NCH-1:0] casc_en,
    input  logic           hlda,
    input  logic           eop_in,
    output logic           hrq,
    output logic [NCH-1:0] grant,
    output logic           casc_own
);
    arb_state_t     state_q;
    logic [NCH-1:0] grant_q;
    logic           casc_q;
    logic           win_live;

    assign win_live = |(qual & grant_q);

    // State, winner and cascade flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            casc_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ARB_IDLE: if (any_q) state_q <= ARB_WAIT;
                ARB_WAIT: begin
                    if (!any_q) begin
                        state_q <= ARB_IDLE;
                    end else if (hlda) begin
                        state_q <= ARB_OWN;
                        grant_q <= pick;
                        casc_q  <= |(pick & casc_en);
                    end
                end
                ARB_OWN: begin
                    if (!win_live || (eop_in && !casc_q)) begin
                        state_q <= ARB_IDLE;
                        grant_q <= '0;
                        casc_q  <= 1'b0;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign hrq      = (state_q != ARB_IDLE);
    assign grant    = grant_q;
    assign casc_own = casc_q;

    // R2: never more than one channel granted.
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R1: a qualified request in idle leads to a hold request.
    a_r1_hrq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && any_q) |=> hrq);

    // R4: losing the winner's request releases the bus next edge.
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_OWN && !win_live) |=> (!hrq && grant_q == '0));
endmodule

// File: rtl/dma_dack_drive.sv
// Acknowledge driver: holds the polarity setting in a register that
// resets to active-low and maps the one-hot grant onto the pins.
// Assumes: grant is one-hot or zero.
module dma_dack_drive #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dack_hi,
    input  logic [NCH-1:0] grant,
    output logic [NCH-1:0] dack
);
    logic pol_q;

    // Polarity register, active-low out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= 1'b0;
        else        pol_q <= dack_hi;
    end

    assign dack = pol_q ? grant : ~grant;

    // R7: on the first edge after reset every line is inactive-high.
    a_r7_dack_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dack == '1));
endmodule

// File: rtl/dma_casc_arbiter.sv
// Top of the cascadable DMA request arbiter. It qualifies requests,
// picks by fixed priority, sequences hold request and grant, drives
// acknowledge at the programmed polarity and gates the bus output enables.
// A cascade grant keeps the enables low and ignores external end-of-process.
// Assumes: synchronous active-low reset; inputs synchronous to clk.
module dma_casc_arbiter #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] casc_en,
    input  logic           dack_hi,
    input  logic           hlda,
    input  logic           eop_in,
    output logic           hrq,
    output logic [NCH-1:0] dack,
    output logic           addr_oe,
    output logic           ctrl_oe,
    output logic           eop_oe,
    output logic           eop_take
);
    logic [NCH-1:0] qual;
    logic           any_q;
    logic [NCH-1:0] pick;
    logic [NCH-1:0] grant;
    logic           casc_own;
    logic           local_own;

    dma_req_qual #(.NCH(NCH)) u_qual (
        .dreq (dreq),
        .mask (mask),
        .qual (qual),
        .any_q(any_q)
    );

    dma_prio_pick #(.NCH(NCH)) u_pick (
        .req (qual),
        .pick(pick)
    );

    dma_grant_fsm #(.NCH(NCH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual    (qual),
        .any_q   (any_q),
        .pick    (pick),
        .casc_en (casc_en),
        .hlda    (hlda),
        .eop_in  (eop_in),
        .hrq     (hrq),
        .grant   (grant),
        .casc_own(casc_own)
    );

    dma_dack_drive #(.NCH(NCH)) u_dack (
        .clk    (clk),
        .rst_n  (rst_n),
        .dack_hi(dack_hi),
        .grant  (grant),
        .dack   (dack)
    );

    // Bus enables only for a locally serviced grant.
    assign local_own = (|grant) && !casc_own;
    assign addr_oe   = local_own;
    assign ctrl_oe   = local_own;
    assign eop_oe    = local_own;
    assign eop_take  = eop_in && local_own;

    // R5: a cascade grant keeps every bus enable low while hrq stays high.
    a_r5_casc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        casc_own |-> (hrq && !addr_oe && !ctrl_oe && !eop_oe));

    // R6: external end-of-process never accepted during a cascade grant.
    a_r6_casc_no_eop: assert property (@(posedge clk) disable iff (!rst_n)
        casc_own |-> !eop_take);
endmodule

// File: tb/tb_dma_casc_arbiter.sv
module tb_dma_casc_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dreq = '0, mask = '0, casc_en = '0;
    logic       dack_hi = 1'b0, hlda = 1'b0, eop_in = 1'b0;
    logic       hrq, addr_oe, ctrl_oe, eop_oe, eop_take;
    logic [3:0] dack;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dma_casc_arbiter #(.NCH(4)) dut (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .mask(mask),
        .casc_en(casc_en), .dack_hi(dack_hi), .hlda(hlda), .eop_in(eop_in),
        .hrq(hrq), .dack(dack), .addr_oe(addr_oe), .ctrl_oe(ctrl_oe),
        .eop_oe(eop_oe), .eop_take(eop_take)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // {dreq, mask, casc, hlda, eop, pol, exp_hrq, exp_dack, exp_oe, exp_eop_take}
    localparam int NV = 28;
    localparam logic [21:0] VEC [NV] = '{
        {4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0, 1'b0,4'b1111,1'b0,1'b0}, // idle
        {4'b0100,4'b0000,4'b0000,1'b0,1'b0,1'b0, 1'b1,4'b1111,1'b0,1'b0}, // R1 hrq
        {4'b0110,4'b0000,4'b0000,1'b1,1'b0,1'b0, 1'b1,4'b1101,1'b1,1'b0}, // R2 ch1 beats ch2, R9
        {4'b0110,4'b0000,4'b0000,1'b1,1'b0,1'b0, 1'b1,4'b1101,1'b1,1'b0}, // R4 held
        {4'b0100,4'b0000,4'b0000,1'b1,1'b0,1'b0, 1'b0,4'b1111,1'b0,1'b0}, // R4 release
        {4'b0100,4'b0000,4'b0000,1'b1,1'b0,1'b0, 1'b1,4'b1111,1'b0,1'b0},
        {4'b0100,4'b0000,4'b0000,1'b1,1'b0,1'b0, 1'b1,4'b1011,1'b1,1'b0}, // ch2
        {4'b0100,4'b0000,4'b0000,1'b1,1'b1,1'b0, 1'b0,4'b1111,1'b0,1'b0}, // R6 eop ends normal
        {4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0, 1'b0,4'b1111,1'b0,1'b0},
        {4'b1000,4'b1000,4'b0000,1'b0,1'b0,1'b0, 1'b0,4'b1111,1'b0,1'b0}, // R3 masked no hrq
        {4'b1001,4'b0001,4'b0000,1'b0,1'b0,1'b0, 1'b1,4'b1111,1'b0,1'b0},
        {4'b1001,4'b0001,4'b0000,1'b1,1'b0,1'b0, 1'b1,4'b0111,1'b1,1'b0}, // R3 ch0 masked, ch3 wins
        {4'b0000,4'b0000,4'b0000,1'b0,1'b0,1'b0, 1'b0,4'b1111,1'b0,1'b0},
        {4'b0001,4'b0000,4'b0001,1'b0,1'b0,1'b0, 1'b1,4'b1111,1'b0,1'b0},
        {4'b0001,4'b0000,4'b0001,1'b1,1'b0,1'b0, 1'b1,4'b1110,1'b0,1'b0}, // R5 cascade quiet
        {4'b0001,4'b0000,4'b0001,1'b1,1'b1,1'b0, 1'b1,4'b1110,1'b0,1'b0}, // R6 eop ignored
        {4'b0011,4'b0000,4'b0001,1'b1,1'b0,1'b0, 1'b1,4'b1110,1'b0,1'b0}, // R4 cascade holds
        {4'b0010,4'b0000,4'b0001,1'b1,1'b0,1'b0, 1'b0,4'b1111,1'b0,1'b0}, // R4 release
        {4'b0010,4'b0000,4'b0001,1'b1,1'b0,1'b0, 1'b1,4'b1111,1'b0,1'b0},
        {4'b0010,4'b0000,4'b0001,1'b1,1'b0,1'b0, 1'b1,4'b1101,1'b1,1'b0}, // R9 normal ch1
        {4'b0010,4'b0000,4'b0001,1'b1,1'b0,1'b1, 1'b1,4'b0010,1'b1,1'b0}, // R8 active high
        {4'b0000,4'b0000,4'b0001,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0}, // R8 inactive low
        {4'b0100,4'b0000,4'b0100,1'b0,1'b0,1'b1, 1'b1,4'b0000,1'b0,1'b0},
        {4'b0100,4'b0000,4'b0100,1'b1,1'b0,1'b1, 1'b1,4'b0100,1'b0,1'b0}, // R5 cascade ch2
        {4'b0100,4'b0100,4'b0100,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0}, // R3 mask ends cascade
        {4'b0100,4'b0100,4'b0100,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0}, // R3 stays blocked
        {4'b0100,4'b0000,4'b0100,1'b0,1'b0,1'b1, 1'b1,4'b0000,1'b0,1'b0},
        {4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0}  // R1 drop while waiting
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R7: reset state, with active-high polarity requested during reset.
        dack_hi = 1'b1; dreq = 4'b1111; hlda = 1'b1;
        repeat (3) tick();
        check("R7 hrq", hrq, 0);
        check("R7 dack", dack, 4'b1111);
        check("R7 enables", {addr_oe, ctrl_oe, eop_oe, eop_take}, 0);
        dack_hi = 1'b0; dreq = '0; hlda = 1'b0;
        rst_n = 1'b1;
        tick();
        check("R7 first edge dack", dack, 4'b1111);
        check("R7 first edge hrq", hrq, 0);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VEC[i];
            dreq = v[21:18]; mask = v[17:14]; casc_en = v[13:10];
            hlda = v[9]; eop_in = v[8]; dack_hi = v[7];
            tick();
            check("R1,R4 hrq", hrq, v[6]);
            check("R2,R3,R8 dack", dack, v[5:2]);
            check("R5,R9 addr_oe", addr_oe, v[1]);
            check("R5,R9 ctrl_oe", ctrl_oe, v[1]);
            check("R5,R9 eop_oe", eop_oe, v[1]);
            check("R6 eop_take", eop_take, v[0]);
        end

        // R8: polarity back to active low; R2: all four requesting.
        dreq = 4'b1111; mask = '0; casc_en = '0; hlda = 1'b0; dack_hi = 1'b0;
        tick();
        check("R8 back to low", dack, 4'b1111);
        check("R1 hrq", hrq, 1);
        hlda = 1'b1;
        tick();
        check("R2 ch0 of four", dack, 4'b1110);
        check("R9 oe", addr_oe, 1);
        // R6: external end-of-process accepted in the same cycle, ends grant.
        eop_in = 1'b1;
        #1;
        check("R6 eop_take", eop_take, 1);
        tick();
        check("R6 grant ended", hrq, 0);
        check("R6 dack idle", dack, 4'b1111);
        eop_in = 1'b0; dreq = '0; hlda = 1'b0;
        tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule